// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port with Mode-Fault Detection

This block is a byte-wide serial peripheral port that serves either as bus master or as bus slave. A control register selects the role. In master role the port makes a serial clock from the system clock and runs it only while a word is moving. It launches data on MOSI and takes data in from MISO. In slave role it listens only while its active-low select input is low. It takes data from MOSI and returns data on MISO. All four clock polarity and phase formats are supported. Every outgoing pin has its own data and enable outputs, so pads, pull-ups and open-drain wiring stay outside the block.

A master can find its own select input pulled low. That means another device is also trying to drive the bus. The port then drops the transfer, gives up the clock and MOSI pins, falls back to slave role and raises a sticky error flag. On the slave side, MISO can be made open-drain, or switched off completely so that one master can talk to several slaves at once.

Top module: `spi_dual_port`

## Requirements
- R1: The control register resets to zero (slave role, all options off). Control bit 0 set selects master role: `sclk_oe` and `mosi_oe` are high and `miso_oe` is low. In slave role `sclk_oe` and `mosi_oe` are low.
- R2: A master transfer moves 8 bits MSB first in both directions and makes exactly 16 serial clock edges. The idle clock level equals control bit 1 (polarity). With control bit 2 (phase) at 0, data is sampled on the edge leaving idle and launched on the edge returning to idle. With bit 2 at 1, data is launched on the leaving edge and sampled on the returning edge.
- R3: In master role every half period of the serial clock lasts exactly divider+1 system clocks. The divider is control bits 15:8.
- R4: `done` is a pulse one system clock wide, raised once per completed word. `rx_byte` holds the received word while `done` is high.
- R5: In slave role the port ignores `sclk_i` while `ss_n_i` is high: no done, no received bits, and `miso_oe` stays low. When select falls, `tx_byte` is loaded for return, and the word from MOSI is received in the configured format.
- R6: With control bit 3 (open drain) set, a selected slave drives `miso_o` low with `miso_oe` high only for 0 bits, and releases the pin for 1 bits.
- R7: With control bit 5 set, `miso_oe` stays low throughout a slave transfer, while reception on MOSI still completes.
- R8: When the synchronized select input is low in master role, the port raises `mode_fault`, clears control bit 0, aborts any running transfer without a `done` pulse, and releases `sclk_oe` and `mosi_oe`.
- R9: `mode_fault` stays set until `err_clr`. If a new fault and `err_clr` arrive in the same cycle, the flag stays set. A fault also overrides a same-cycle control write that sets bit 0.
- R10: `start` has no effect in slave role: no clock is driven, no `done` occurs, and `busy` stays low while deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control write data |
| ctrl_q | output | 16 | Control register contents |
| err_clr | input | 1 | Clears the mode-fault flag |
| mode_fault | output | 1 | Sticky multimaster error flag |
| start | input | 1 | Starts a master transfer |
| tx_byte | input | 8 | Word to transmit |
| busy | output | 1 | Master transfer running or slave selected |
| done | output | 1 | One-cycle word-complete pulse |
| rx_byte | output | 8 | Last received word |
| sclk_i | input | 1 | Serial clock pin input |
| sclk_o | output | 1 | Serial clock pin output |
| sclk_oe | output | 1 | Serial clock output enable |
| ss_n_i | input | 1 | Active-low select pin input |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe | output | 1 | MISO output enable |

## Verification
The mode-fault detector and software's error clear can act on the flag in the same cycle. The fault detector's clearing of the role bit can also meet a control write that sets that bit. The bench holds select low in slave role, writes master role, and asserts `err_clr` in the very next cycle, which is the cycle in which the fault fires. It then expects the flag to read set and the role bit to read cleared. A master transfer is also interrupted by a fault partway through. The bench judges that case by the missing `done` pulse and the released clock and MOSI enables.

// File: rtl/spi_dp_pkg.sv
// Package: shared control-register layout and widths for the dual-role port.
// Assumes a 16-bit control word; bit positions are decoded by the top module.
package spi_dp_pkg;

    localparam int CTRL_W = 16;
    localparam int DIV_W  = 8;

    // Control register: divider high byte, option bits low byte.
    typedef struct packed {
        logic [DIV_W-1:0] div;        // half-period minus one, in system clocks
        logic [1:0]       rsv_hi;     // reads zero
        logic             miso_off;   // bit 5: slave never drives MISO
        logic             rsv_lo;     // reads zero
        logic             open_drain; // bit 3: MISO drives low only
        logic             cpha;       // bit 2: launch on leaving edge
        logic             cpol;       // bit 1: idle clock level
        logic             master;     // bit 0: master role
    } ctrl_t;

endpackage

// File: rtl/spi_dp_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous pin inputs.
// Assumes each bit is independent; reset value per bit is a parameter.
module spi_dp_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each later stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= RST_VAL;
                else        stg[gi] <= stg[gi-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_dp_master.sv
// Module: master engine. Generates the gated serial clock, shifts out MOSI
// and samples MISO. Assumes cpol/cpha/div are held stable during a word.
// Edges are numbered 0..2W-1; even numbers leave idle, odd ones return.
module spi_dp_master #(
    parameter int W  = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          abort,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [DW-1:0] div,
    input  logic          start,
    input  logic [W-1:0]  tx,
    input  logic          miso_i,
    output logic          sclk,
    output logic          mosi,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  rx
);

    localparam int             EW   = $clog2(2*W);
    localparam logic [EW-1:0]  LAST = EW'(2*W-1);

    logic          run, ph;
    logic [DW-1:0] dcnt;
    logic [EW-1:0] ecnt;
    logic [W-1:0]  tsr, rsr, rsr_nx;
    logic          lead, smp, shf, tick;

    // Decode what the next clock edge does from its number and the phase.
    always_comb begin
        tick   = run && (dcnt == div);
        lead   = ~ecnt[0];
        smp    = cpha ? ~lead : lead;
        shf    = cpha ? (lead && ecnt != '0) : (~lead && ecnt != LAST);
        rsr_nx = {rsr[W-2:0], miso_i};
    end

    // Sequencer: divider, edge counter, shift registers, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            ph   <= 1'b0;
            dcnt <= '0;
            ecnt <= '0;
            tsr  <= '0;
            rsr  <= '0;
            rx   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort || !en) begin
                run <= 1'b0;
                ph  <= 1'b0;
            end else if (!run) begin
                ph <= 1'b0;
                if (start) begin
                    run  <= 1'b1;
                    tsr  <= tx;
                    dcnt <= '0;
                    ecnt <= '0;
                end
            end else if (tick) begin
                dcnt <= '0;
                ph   <= ~ph;
                ecnt <= ecnt + EW'(1);
                if (smp) rsr <= rsr_nx;
                if (shf) tsr <= {tsr[W-2:0], 1'b0};
                if (ecnt == LAST) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                    rx   <= smp ? rsr_nx : rsr;
                end
            end else begin
                dcnt <= dcnt + DW'(1);
            end
        end
    end

    assign sclk = ph ^ cpol;
    assign mosi = tsr[W-1];
    assign busy = run;

endmodule

// File: rtl/spi_dp_slave.sv
// Module: slave engine. Works on synchronized pin copies, detects serial
// clock edges in the system clock domain, and only while selected.
// Assumes the serial clock is several system clocks slower per half period.
module spi_dp_slave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         sclk_s,
    input  logic         ss_s,
    input  logic         mosi_s,
    input  logic [W-1:0] tx,
    output logic         miso_bit,
    output logic         sel,
    output logic         done,
    output logic [W-1:0] rx
);

    localparam int            CW    = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LASTB = CW'(W-1);

    logic          sclk_d, ss_d;
    logic [CW-1:0] cnt;
    logic [W-1:0]  tsr, rsr, rnx;
    logic          rise, fall, lead, trail, smp, shf;

    // Edge classification relative to the idle level, gated by select.
    always_comb begin
        sel   = en && !ss_s;
        rise  = sclk_s && !sclk_d;
        fall  = !sclk_s && sclk_d;
        lead  = cpol ? fall : rise;
        trail = cpol ? rise : fall;
        smp   = sel && (cpha ? trail : lead);
        shf   = sel && (cpha ? lead : trail) && (cnt != '0);
        rnx   = {rsr[W-2:0], mosi_s};
    end

    // Bit engine: load on select, sample and shift on decoded edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            ss_d   <= 1'b1;
            cnt    <= '0;
            tsr    <= '0;
            rsr    <= '0;
            rx     <= '0;
            done   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            ss_d   <= ss_s;
            done   <= 1'b0;
            if (!sel) begin
                cnt <= '0;
            end else if (ss_d) begin
                tsr <= tx;
                cnt <= '0;
            end else if (smp) begin
                rsr <= rnx;
                if (cnt == LASTB) begin
                    done <= 1'b1;
                    rx   <= rnx;
                    cnt  <= '0;
                    tsr  <= tx;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else if (shf) begin
                tsr <= {tsr[W-2:0], 1'b0};
            end
        end
    end

    assign miso_bit = tsr[W-1];

endmodule

// File: rtl/spi_dual_port.sv
// Module: dual-role serial port top. Holds the control register and the
// fault flag, synchronizes the pins, and steers the two engines onto the
// pin data/enable outputs. Assumes external pull-ups on all shared lines.
module spi_dual_port #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ctrl_we,
    input  logic [spi_dp_pkg::CTRL_W-1:0] ctrl_wdata,
    output logic [spi_dp_pkg::CTRL_W-1:0] ctrl_q,
    input  logic                         err_clr,
    output logic                         mode_fault,
    input  logic                         start,
    input  logic [WORD_W-1:0]            tx_byte,
    output logic                         busy,
    output logic                         done,
    output logic [WORD_W-1:0]            rx_byte,
    input  logic                         sclk_i,
    output logic                         sclk_o,
    output logic                         sclk_oe,
    input  logic                         ss_n_i,
    input  logic                         mosi_i,
    output logic                         mosi_o,
    output logic                         mosi_oe,
    input  logic                         miso_i,
    output logic                         miso_o,
    output logic                         miso_oe
);

    import spi_dp_pkg::*;

    ctrl_t              ctrl;
    ctrl_t              wr;
    logic               ss_sync, sclk_sync, mosi_sync;
    logic               fault_evt;
    logic               m_sclk, m_mosi, m_busy, m_done;
    logic [WORD_W-1:0]  m_rx, s_rx;
    logic               s_bit, s_sel, s_done;

    spi_dp_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, sclk_i, mosi_i}),
        .q     ({ss_sync, sclk_sync, mosi_sync})
    );

    // Fault condition and the write word with reserved bits forced to zero.
    always_comb begin
        fault_evt     = ctrl.master && !ss_sync;
        wr            = ctrl_t'(ctrl_wdata);
        wr.rsv_hi     = '0;
        wr.rsv_lo     = 1'b0;
    end

    // Control register; a fault overrides any write of the role bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (ctrl_we)   ctrl        <= wr;
            if (fault_evt) ctrl.master <= 1'b0;
        end
    end

    // Sticky fault flag; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_fault <= 1'b0;
        else if (fault_evt) mode_fault <= 1'b1;
        else if (err_clr)   mode_fault <= 1'b0;
    end

    spi_dp_master #(
        .W  (WORD_W),
        .DW (DIV_W)
    ) u_master (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl.master),
        .abort  (fault_evt),
        .cpol   (ctrl.cpol),
        .cpha   (ctrl.cpha),
        .div    (ctrl.div),
        .start  (start && ctrl.master),
        .tx     (tx_byte),
        .miso_i (miso_i),
        .sclk   (m_sclk),
        .mosi   (m_mosi),
        .busy   (m_busy),
        .done   (m_done),
        .rx     (m_rx)
    );

    spi_dp_slave #(
        .W (WORD_W)
    ) u_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (!ctrl.master),
        .cpol     (ctrl.cpol),
        .cpha     (ctrl.cpha),
        .sclk_s   (sclk_sync),
        .ss_s     (ss_sync),
        .mosi_s   (mosi_sync),
        .tx       (tx_byte),
        .miso_bit (s_bit),
        .sel      (s_sel),
        .done     (s_done),
        .rx       (s_rx)
    );

    // Pin steering by role and MISO options.
    always_comb begin
        ctrl_q  = ctrl;
        sclk_o  = m_sclk;
        sclk_oe = ctrl.master;
        mosi_o  = m_mosi;
        mosi_oe = ctrl.master;
        miso_o  = ctrl.open_drain ? 1'b0 : s_bit;
        miso_oe = s_sel && !ctrl.miso_off && (ctrl.open_drain ? !s_bit : 1'b1);
        busy    = m_busy || s_sel;
        done    = m_done || s_done;
        rx_byte = ctrl.master ? m_rx : s_rx;
    end

endmodule

// File: rtl/spi_dp_chk.sv
// Module: property checker for the dual-role port, attached by bind.
// Assumes it observes the top's ports plus the synchronized select.
module spi_dp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] ctrl_q,
    input logic        err_clr,
    input logic        mode_fault,
    input logic        done,
    input logic        busy,
    input logic        sclk_o,
    input logic        sclk_oe,
    input logic        mosi_oe,
    input logic        miso_o,
    input logic        miso_oe,
    input logic        ss_sync
);

    // R1
    master_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |-> (sclk_oe && mosi_oe && !miso_oe));

    // R1
    slave_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |-> (!sclk_oe && !mosi_oe));

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && !busy) |-> (sclk_o == ctrl_q[1]));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !ss_sync);

    // R6
    open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3] && miso_oe) |-> !miso_o);

    // R7
    broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[5] |-> !miso_oe);

    // R8
    fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && !ss_sync) |=> (mode_fault && !ctrl_q[0]));

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fault && !err_clr) |=> mode_fault);

endmodule

bind spi_dual_port spi_dp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_q     (ctrl_q),
    .err_clr    (err_clr),
    .mode_fault (mode_fault),
    .done       (done),
    .busy       (busy),
    .sclk_o     (sclk_o),
    .sclk_oe    (sclk_oe),
    .mosi_oe    (mosi_oe),
    .miso_o     (miso_o),
    .miso_oe    (miso_oe),
    .ss_sync    (ss_sync)
);

// File: tb/tb_spi_dual_port.sv
module tb_spi_dual_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic        clk, rst_n;
    logic        ctrl_we;
    logic [15:0] ctrl_wdata, ctrl_q;
    logic        err_clr, mode_fault, start, busy, done;
    logic [7:0]  tx_byte, rx_byte;
    logic        sclk_i, sclk_o, sclk_oe, ss_n_i;
    logic        mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;

    spi_dual_port dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .err_clr(err_clr), .mode_fault(mode_fault),
        .start(start), .tx_byte(tx_byte), .busy(busy), .done(done),
        .rx_byte(rx_byte), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .ss_n_i(ss_n_i), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    int vectors = 0, miscompares = 0;
    int cyc = 0, done_cnt = 0;
    bit oe_seen, od_bad;
    bit mm_on, mm_prev, mm_cpha, period_bad;
    int mm_edges, mm_bit, mm_div, mm_last;
    logic [7:0] mm_tx, mm_cap, last_rx;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One system clock; observe outputs and play the remote slave when armed.
    task automatic tick();
        bit lead, smp, shf;
        @(negedge clk);
        cyc++;
        if (done) begin done_cnt++; last_rx = rx_byte; end
        if (miso_oe) oe_seen = 1'b1;
        if (miso_oe && miso_o) od_bad = 1'b1;
        if (mm_on && sclk_o != mm_prev) begin
            lead = (mm_edges % 2 == 0);
            smp  = mm_cpha ? !lead : lead;
            shf  = mm_cpha ? (lead && mm_edges != 0) : !lead;
            if (mm_edges > 0 && (cyc - mm_last) != mm_div + 1) period_bad = 1'b1;
            mm_last = cyc;
            if (smp) mm_cap = {mm_cap[6:0], mosi_o};
            if (shf && mm_bit < 7) begin mm_bit++; miso_i = mm_tx[7-mm_bit]; end
            mm_edges++;
        end
        mm_prev = sclk_o;
    endtask

    task automatic wr_ctrl(input bit m, input bit pol, input bit pha, input bit od,
                           input bit off, input logic [7:0] dv);
        ctrl_we    = 1'b1;
        ctrl_wdata = {dv, 2'b00, off, 1'b0, od, pha, pol, m};
        tick();
        ctrl_we = 1'b0;
    endtask

    function automatic logic [7:0] line_exp(input logic [7:0] d, input bit off);
        return off ? 8'hFF : d;
    endfunction

    task automatic master_xfer(input bit pol, input bit pha, input logic [7:0] dv,
                               input logic [7:0] tx, input logic [7:0] sd);
        int d0;
        wr_ctrl(1'b1, pol, pha, 1'b0, 1'b0, dv);
        tick();
        check(sclk_o == pol, "R2 idle level", sclk_o, pol);
        check(sclk_oe && mosi_oe && !miso_oe, "R1 master enables",
              {sclk_oe, mosi_oe, miso_oe}, 3'b110);
        mm_on = 1'b1; mm_prev = sclk_o; mm_edges = 0; mm_bit = 0; mm_tx = sd;
        mm_cap = 8'h00; period_bad = 1'b0; mm_cpha = pha; mm_div = int'(dv);
        miso_i = sd[7];
        d0 = done_cnt;
        tx_byte = tx; start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 3000 && done_cnt == d0; i++) tick();
        repeat (2) tick();
        check(done_cnt == d0 + 1, "R4 single done pulse", done_cnt - d0, 1);
        check(last_rx == sd, "R2 master rx", last_rx, sd);
        check(mm_cap == tx, "R2 master mosi", mm_cap, tx);
        check(mm_edges == 16, "R2 edge count", mm_edges, 16);
        check(!period_bad, "R3 half period", period_bad, 0);
        check(sclk_o == pol && !busy, "R2 back to idle", {sclk_o, busy}, {pol, 1'b0});
        mm_on = 1'b0;
    endtask

    task automatic slave_xfer(input bit pol, input bit pha, input bit od, input bit off,
                              input logic [7:0] tx, input logic [7:0] md);
        int d0;
        logic [7:0] cap;
        wr_ctrl(1'b0, pol, pha, od, off, 8'h00);
        sclk_i = pol; ss_n_i = 1'b1;
        repeat (4) tick();
        check(!miso_oe, "R5 deselected miso", miso_oe, 0);
        tx_byte = tx; oe_seen = 1'b0; od_bad = 1'b0; d0 = done_cnt; cap = 8'h00;
        ss_n_i = 1'b0;
        repeat (6) tick();
        for (int i = 0; i < 8; i++) begin
            if (!pha) mosi_i = md[7-i];
            repeat (HALF) tick();
            if (!pha) cap = {cap[6:0], (miso_oe ? miso_o : 1'b1)};
            sclk_i = ~pol;
            if (pha) mosi_i = md[7-i];
            repeat (HALF) tick();
            if (pha) cap = {cap[6:0], (miso_oe ? miso_o : 1'b1)};
            sclk_i = pol;
        end
        repeat (6) tick();
        check(done_cnt == d0 + 1, "R5 slave done", done_cnt - d0, 1);
        check(last_rx == md, "R5 slave rx", last_rx, md);
        check(cap == line_exp(tx, off), off ? "R7 miso line" : "R6 miso line",
              cap, line_exp(tx, off));
        if (od)  check(!od_bad, "R6 no high drive", od_bad, 0);
        if (off) check(!oe_seen, "R7 miso never enabled", oe_seen, 0);
        ss_n_i = 1'b1;
        repeat (4) tick();
    endtask

    initial begin
        void'($urandom(32'h1C3A_77E5));
        rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; err_clr = 1'b0; start = 1'b0;
        tx_byte = '0; sclk_i = 1'b0; ss_n_i = 1'b1; mosi_i = 1'b1; miso_i = 1'b1;
        mm_on = 1'b0; mm_prev = 1'b0; mm_last = 0; period_bad = 1'b0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(ctrl_q == 16'h0 && !mode_fault, "R1 reset ctrl", ctrl_q, 0);
        check(!sclk_oe && !mosi_oe && !miso_oe && !busy && !done, "R1 reset pins",
              {sclk_oe, mosi_oe, miso_oe, busy, done}, 0);

        // R2 R3 directed corner words in every format
        for (int m = 0; m < 4; m++) begin
            master_xfer(m[1], m[0], 8'd0, 8'h00, 8'hFF);
            master_xfer(m[1], m[0], 8'd2, 8'hA5, 8'h3C);
        end
        // R2 R3 R4 random master words
        for (int n = 0; n < 20; n++)
            master_xfer(1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
                        8'($urandom_range(0,3)), 8'($urandom), 8'($urandom));

        // R10 start in slave role
        begin
            int d0;
            wr_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0);
            d0 = done_cnt;
            start = 1'b1; tick(); start = 1'b0;
            repeat (40) tick();
            check(done_cnt == d0 && !busy && !sclk_oe, "R10 start ignored",
                  {done_cnt - d0, busy, sclk_oe}, 0);
        end

        // R5 serial clock ignored while deselected
        begin
            int d0;
            d0 = done_cnt;
            for (int i = 0; i < 20; i++) begin
                sclk_i = ~sclk_i; mosi_i = 1'($urandom_range(0,1));
                repeat (3) tick();
            end
            sclk_i = 1'b0;
            repeat (4) tick();
            check(done_cnt == d0 && !busy && !miso_oe, "R5 ignored clock",
                  {done_cnt - d0, busy, miso_oe}, 0);
        end

        // R5 R6 R7 slave formats and MISO options
        for (int m = 0; m < 4; m++) slave_xfer(m[1], m[0], 1'b0, 1'b0, 8'h96, 8'h5A);
        slave_xfer(1'b0, 1'b0, 1'b1, 1'b0, 8'h0F, 8'hC3);
        slave_xfer(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h81);
        for (int n = 0; n < 14; n++)
            slave_xfer(1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
                       1'($urandom_range(0,1)), ($urandom_range(0,3) == 0),
                       8'($urandom), 8'($urandom));

        // R8 fault mid-transfer
        begin
            int d0;
            wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3);
            d0 = done_cnt;
            tx_byte = 8'h77; start = 1'b1; tick(); start = 1'b0;
            repeat (20) tick();
            ss_n_i = 1'b0;
            repeat (6) tick();
            check(mode_fault && !ctrl_q[0], "R8 fault raised", {mode_fault, ctrl_q[0]}, 2'b10);
            check(!sclk_oe && !mosi_oe, "R8 pins released", {sclk_oe, mosi_oe}, 0);
            repeat (80) tick();
            check(done_cnt == d0, "R8 no done", done_cnt - d0, 0);
            ss_n_i = 1'b1;
            repeat (4) tick();
            check(mode_fault, "R9 sticky", mode_fault, 1);
            err_clr = 1'b1; tick(); err_clr = 1'b0;
            check(!mode_fault, "R9 cleared", mode_fault, 0);
        end

        // R9 fault and clear in the same cycle
        ss_n_i = 1'b0;
        repeat (4) tick();
        ctrl_we = 1'b1; ctrl_wdata = 16'h0001;
        tick();
        ctrl_we = 1'b0; err_clr = 1'b1;
        tick();
        err_clr = 1'b0;
        check(mode_fault && !ctrl_q[0], "R9 set beats clear", {mode_fault, ctrl_q[0]}, 2'b10);
        ss_n_i = 1'b1;
        repeat (4) tick();
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        tick();
        check(!mode_fault, "R9 final clear", mode_fault, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule